// File: doc/BRIEF.md
# Watchdog and Reset Sequencer

This block supervises a processor. It keeps the processor in reset while the supply is low and during a fixed delay after the supply comes back. After that it watches a software heartbeat line. The supply condition reaches the block as a digital supply-good flag from an external comparator. Time is counted in ticks of a pre-divided timebase. A two-bit mode input chooses which set of tick counts applies: the internal slow timebase, the internal fast timebase, or an external clock.

Once reset is released, the watchdog waits for an edge on the heartbeat line. Rising and falling edges both count. The first wait after each reset release is long. Every later wait uses the steady period of the selected mode. If a wait runs out with no edge, two things happen:

- the fault flag latches low;
- reset is pulsed for the full reset timeout.

A heartbeat that never moves therefore produces a reset pulse once every long period. The watchdog is switched off, with the fault flag high, while the supply is low or while the heartbeat line is reported as floating.

Top module: `sup_reset_seq`

## Requirements
- R1: While `supply_ok` is 0, `rst_out_n` is 0 in the same cycle, with no clock edge needed.
- R2: After `supply_ok` returns to 1, `rst_out_n` rises on the clock edge that counts the reset-timeout-th tick seen with `supply_ok` high. The timeout is `EXT_RST_TICKS` in the external modes and `INT_RST_TICKS` in both internal modes.
- R3: `rst_out` is always the complement of `rst_out_n`.
- R4: In steady state the watchdog period is the steady count of the mode. Mode encodings: `tb_mode` 2'b00 is internal slow, 2'b01 is internal fast, 2'b10 and 2'b11 are external. Steady counts: `INT_WD_FAST_TICKS` for internal fast, `EXT_WD_SHORT_TICKS` for external.
- R5: The first watchdog period after each reset release lasts the long count: `INT_WD_SLOW_TICKS` in both internal modes, `EXT_WD_LONG_TICKS` in the external modes.
- R6: Every rising or falling edge of `hb_in` restarts the watchdog count. Each edge takes effect three clock edges after it is presented, and each edge of a pulse one clock wide counts.
- R7: When a period expires with no edge, `wdog_fault_n` falls and `rst_out_n` falls on the same edge. Reset stays low for the mode's reset timeout. `wdog_fault_n` stays low, through and after that pulse, until the third clock edge after the next heartbeat edge.
- R8: With `hb_in` held still, reset pulses repeat forever. Each release is followed by exactly one long period before the next pulse.
- R9: While `supply_ok` is low, or `hb_float` is 1, `wdog_fault_n` is high and no watchdog reset occurs. The flag returns high one clock edge after `supply_ok` falls, or three clock edges after `hb_float` rises.
- R10: In internal slow mode the steady period equals the long count `INT_WD_SLOW_TICKS`.
- R11: The reset and watchdog counters advance only on cycles where `tick` is 1. Without ticks, reset is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| supply_ok | input | 1 | Digitized supply-above-threshold flag |
| hb_in | input | 1 | Software heartbeat line |
| hb_float | input | 1 | Heartbeat line is left floating |
| tb_mode | input | 2 | Timebase mode select |
| tick | input | 1 | One-cycle timebase strobe |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| wdog_fault_n | output | 1 | Watchdog fault flag, active low |

## Verification
The assertions assume that `supply_ok`, `tick` and `tb_mode` are synchronous to `clk`. They also assume that `tb_mode` only changes while the supply is low, because the limits of a running count would otherwise shift. Only `hb_in` and `hb_float` are treated as asynchronous; they pass through the synchronizer, and a heartbeat pulse must cover at least one full clock. The stimulus respects all of this: it changes every input just after a rising edge, switches modes only after first dropping `supply_ok`, and holds each heartbeat level for whole cycles.

// File: rtl/sup_pkg.sv
package sup_pkg;

   typedef enum logic [1:0] {
      TB_INT_SLOW = 2'b00,
      TB_INT_FAST = 2'b01,
      TB_EXT      = 2'b10,
      TB_EXT_ALT  = 2'b11
   } tb_mode_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_hb_front.sv
module sup_hb_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic hb_in,
   input  logic hb_float,
   output logic hb_edge,
   output logic float_s
);
   logic [1:0] synced;
   logic       hb_s;
   logic       hb_prev;

   sup_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      ({hb_float, hb_in}),
      .q      (synced)
   );

   assign hb_s    = synced[0];
   assign float_s = synced[1];

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) hb_prev <= 1'b0;
      else         hb_prev <= hb_s;
   end

   assign hb_edge = hb_s ^ hb_prev;
endmodule

// File: rtl/sup_period_sel.sv
module sup_period_sel
   import sup_pkg::*;
#(
   parameter int CW                 = 16,
   parameter bit HAS_EXT_TB         = 1'b1,
   parameter int INT_RST_TICKS      = 2000,
   parameter int INT_WD_FAST_TICKS  = 1000,
   parameter int INT_WD_SLOW_TICKS  = 16000,
   parameter int EXT_RST_TICKS      = 2048,
   parameter int EXT_WD_SHORT_TICKS = 1024,
   parameter int EXT_WD_LONG_TICKS  = 4096
) (
   input  logic [1:0]    tb_mode,
   output logic [CW-1:0] rst_lim,
   output logic [CW-1:0] wd_first_lim,
   output logic [CW-1:0] wd_steady_lim
);
   localparam logic [CW-1:0] L_INT_RST  = CW'(INT_RST_TICKS);
   localparam logic [CW-1:0] L_INT_FAST = CW'(INT_WD_FAST_TICKS);
   localparam logic [CW-1:0] L_INT_SLOW = CW'(INT_WD_SLOW_TICKS);
   localparam logic [CW-1:0] L_EXT_RST  = CW'(EXT_RST_TICKS);
   localparam logic [CW-1:0] L_EXT_SHRT = CW'(EXT_WD_SHORT_TICKS);
   localparam logic [CW-1:0] L_EXT_LONG = CW'(EXT_WD_LONG_TICKS);

   tb_mode_e mode;
   logic     ext_sel;

   assign mode = tb_mode_e'(tb_mode);

   generate
      if (HAS_EXT_TB) begin : g_ext
         assign ext_sel = (mode == TB_EXT) || (mode == TB_EXT_ALT);
      end else begin : g_no_ext
         assign ext_sel = 1'b0;
      end
   endgenerate

   always_comb begin
      if (ext_sel) begin
         rst_lim       = L_EXT_RST;
         wd_first_lim  = L_EXT_LONG;
         wd_steady_lim = L_EXT_SHRT;
      end else begin
         rst_lim       = L_INT_RST;
         wd_first_lim  = L_INT_SLOW;
         wd_steady_lim = (mode == TB_INT_FAST) ? L_INT_FAST : L_INT_SLOW;
      end
   end
endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          supply_ok,
   input  logic          tick,
   input  logic          wd_expire,
   input  logic [CW-1:0] rst_lim,
   output logic          hold,
   output logic [CW-1:0] cnt
);
   logic last_tick;

   assign last_tick = (cnt == rst_lim - CW'(1));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hold <= 1'b1;
         cnt  <= '0;
      end else if (!supply_ok || wd_expire) begin
         hold <= 1'b1;
         cnt  <= '0;
      end else if (hold && tick) begin
         if (last_tick) begin
            hold <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt  <= cnt + CW'(1);
         end
      end
   end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          supply_ok,
   input  logic          float_s,
   input  logic          hb_edge,
   input  logic          tick,
   input  logic          hold,
   input  logic [CW-1:0] first_lim,
   input  logic [CW-1:0] steady_lim,
   output logic          expire,
   output logic          fault
);
   logic [CW-1:0] cnt;
   logic          first;
   logic          enable;
   logic [CW-1:0] lim;

   assign enable = supply_ok && !float_s && !hold;
   assign lim    = first ? first_lim : steady_lim;
   assign expire = enable && !hb_edge && tick && (cnt == lim - CW'(1));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt   <= '0;
         first <= 1'b1;
      end else if (!enable) begin
         cnt <= '0;
         if (hold || !supply_ok) first <= 1'b1;
      end else if (hb_edge) begin
         cnt   <= '0;
         first <= 1'b0;
      end else if (tick) begin
         if (expire) begin
            cnt   <= '0;
            first <= 1'b1;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                              fault <= 1'b0;
      else if (!supply_ok || float_s || hb_edge) fault <= 1'b0;
      else if (expire)                           fault <= 1'b1;
   end
endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq
   import sup_pkg::*;
#(
   parameter int SYNC_STAGES        = 2,
   parameter bit HAS_EXT_TB         = 1'b1,
   parameter int INT_RST_TICKS      = 2000,
   parameter int INT_WD_FAST_TICKS  = 1000,
   parameter int INT_WD_SLOW_TICKS  = 16000,
   parameter int EXT_RST_TICKS      = 2048,
   parameter int EXT_WD_SHORT_TICKS = 1024,
   parameter int EXT_WD_LONG_TICKS  = 4096
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       supply_ok,
   input  logic       hb_in,
   input  logic       hb_float,
   input  logic [1:0] tb_mode,
   input  logic       tick,
   output logic       rst_out_n,
   output logic       rst_out,
   output logic       wdog_fault_n
);
   localparam int MAX_INT = max_of(INT_RST_TICKS, max_of(INT_WD_FAST_TICKS, INT_WD_SLOW_TICKS));
   localparam int MAX_EXT = max_of(EXT_RST_TICKS, max_of(EXT_WD_SHORT_TICKS, EXT_WD_LONG_TICKS));
   localparam int MAX_T   = max_of(MAX_INT, MAX_EXT);
   localparam int CW      = $clog2(MAX_T + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sup_reset_seq: SYNC_STAGES must be at least 2");
      end
      if (INT_RST_TICKS < 2 || INT_WD_FAST_TICKS < 2 || INT_WD_SLOW_TICKS < 2) begin : g_bad_int
         $error("sup_reset_seq: internal tick counts must be at least 2");
      end
      if (EXT_RST_TICKS < 2 || EXT_WD_SHORT_TICKS < 2 || EXT_WD_LONG_TICKS < 2) begin : g_bad_ext
         $error("sup_reset_seq: external tick counts must be at least 2");
      end
      if (INT_WD_SLOW_TICKS < INT_WD_FAST_TICKS || EXT_WD_LONG_TICKS < EXT_WD_SHORT_TICKS) begin : g_bad_order
         $error("sup_reset_seq: long watchdog period shorter than steady period");
      end
   endgenerate

   logic          hb_edge;
   logic          float_s;
   logic [CW-1:0] rst_lim;
   logic [CW-1:0] wd_first_lim;
   logic [CW-1:0] wd_steady_lim;
   logic          hold;
   logic [CW-1:0] rst_cnt;
   logic          wd_expire;
   logic          wd_fault;

   sup_hb_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk      (clk),
      .arst_n   (arst_n),
      .hb_in    (hb_in),
      .hb_float (hb_float),
      .hb_edge  (hb_edge),
      .float_s  (float_s)
   );

   sup_period_sel #(
      .CW                 (CW),
      .HAS_EXT_TB         (HAS_EXT_TB),
      .INT_RST_TICKS      (INT_RST_TICKS),
      .INT_WD_FAST_TICKS  (INT_WD_FAST_TICKS),
      .INT_WD_SLOW_TICKS  (INT_WD_SLOW_TICKS),
      .EXT_RST_TICKS      (EXT_RST_TICKS),
      .EXT_WD_SHORT_TICKS (EXT_WD_SHORT_TICKS),
      .EXT_WD_LONG_TICKS  (EXT_WD_LONG_TICKS)
   ) u_sel (
      .tb_mode       (tb_mode),
      .rst_lim       (rst_lim),
      .wd_first_lim  (wd_first_lim),
      .wd_steady_lim (wd_steady_lim)
   );

   sup_rst_gen #(.CW(CW)) u_rst (
      .clk       (clk),
      .arst_n    (arst_n),
      .supply_ok (supply_ok),
      .tick      (tick),
      .wd_expire (wd_expire),
      .rst_lim   (rst_lim),
      .hold      (hold),
      .cnt       (rst_cnt)
   );

   sup_wdog #(.CW(CW)) u_wdog (
      .clk        (clk),
      .arst_n     (arst_n),
      .supply_ok  (supply_ok),
      .float_s    (float_s),
      .hb_edge    (hb_edge),
      .tick       (tick),
      .hold       (hold),
      .first_lim  (wd_first_lim),
      .steady_lim (wd_steady_lim),
      .expire     (wd_expire),
      .fault      (wd_fault)
   );

   assign rst_out_n    = supply_ok && !hold;
   assign rst_out      = !rst_out_n;
   assign wdog_fault_n = !wd_fault;
endmodule

// File: rtl/sup_reset_seq_chk.sv
module sup_reset_seq_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          arst_n,
   input logic          supply_ok,
   input logic          hb_float,
   input logic          tick,
   input logic          rst_out_n,
   input logic          wdog_fault_n,
   input logic [CW-1:0] r_cnt,
   input logic [CW-1:0] r_lim
);
   p_supply_drop_r1: assert property (@(posedge clk) disable iff (!arst_n)
      !supply_ok |-> !rst_out_n);

   p_release_needs_supply_r2: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(rst_out_n) |-> (supply_ok && $past(supply_ok)));

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!arst_n)
      r_cnt < r_lim);

   p_fault_with_reset_r7: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(wdog_fault_n) |-> !rst_out_n);

   p_float_quiet_r9: assert property (@(posedge clk) disable iff (!arst_n)
      $past(hb_float, 3) |-> wdog_fault_n);

   p_supply_quiet_r9: assert property (@(posedge clk) disable iff (!arst_n)
      !$past(supply_ok) |-> wdog_fault_n);

   p_no_tick_hold_r11: assert property (@(posedge clk) disable iff (!arst_n)
      (supply_ok && !tick && !rst_out_n) |=> (r_cnt == $past(r_cnt)));
endmodule

bind sup_reset_seq sup_reset_seq_chk #(.CW(CW)) u_chk (
   .clk          (clk),
   .arst_n       (arst_n),
   .supply_ok    (supply_ok),
   .hb_float     (hb_float),
   .tick         (tick),
   .rst_out_n    (rst_out_n),
   .wdog_fault_n (wdog_fault_n),
   .r_cnt        (rst_cnt),
   .r_lim        (rst_lim)
);

// File: tb/sim_sup_reset_seq.sv
`timescale 1ns/1ps
module sim_sup_reset_seq;
   localparam int I_RST  = 12;
   localparam int I_FAST = 6;
   localparam int I_SLOW = 48;
   localparam int E_RST  = 16;
   localparam int E_SHRT = 8;
   localparam int E_LONG = 32;

   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic       supply_ok = 1'b0;
   logic       hb_in = 1'b0;
   logic       hb_float = 1'b0;
   logic [1:0] tb_mode = 2'b10;
   logic       tick = 1'b1;
   logic       rst_out_n, rst_out, wdog_fault_n;

   int checks = 0;
   int fails  = 0;
   int tick_mode = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sup_reset_seq #(
      .INT_RST_TICKS(I_RST), .INT_WD_FAST_TICKS(I_FAST), .INT_WD_SLOW_TICKS(I_SLOW),
      .EXT_RST_TICKS(E_RST), .EXT_WD_SHORT_TICKS(E_SHRT), .EXT_WD_LONG_TICKS(E_LONG)
   ) u0 (
      .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .hb_in(hb_in),
      .hb_float(hb_float), .tb_mode(tb_mode), .tick(tick),
      .rst_out_n(rst_out_n), .rst_out(rst_out), .wdog_fault_n(wdog_fault_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int m_active, m_rcnt, m_wcnt, m_first, m_fault;
   bit hq[$];
   bit fq[$];

   function automatic int lim_rst(input logic [1:0] m);
      return m[1] ? E_RST : I_RST;
   endfunction
   function automatic int lim_long(input logic [1:0] m);
      return m[1] ? E_LONG : I_SLOW;
   endfunction
   function automatic int lim_steady(input logic [1:0] m);
      if (m[1]) return E_SHRT;
      return (m == 2'b01) ? I_FAST : I_SLOW;
   endfunction

   always @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         m_active = 1; m_rcnt = 0; m_wcnt = 0; m_first = 1; m_fault = 0;
         hq = '{0, 0, 0};
         fq = '{0, 0, 0};
      end else begin
         bit e, fl, en, ex;
         int rl, wl;
         e  = hq[1] ^ hq[2];
         fl = fq[1];
         rl = lim_rst(tb_mode);
         wl = (m_first != 0) ? lim_long(tb_mode) : lim_steady(tb_mode);
         en = supply_ok && !fl && (m_active == 0);
         ex = en && !e && tick && (m_wcnt + 1 == wl);
         if (!supply_ok || fl || e) m_fault = 0;
         else if (ex) m_fault = 1;
         if (!en) begin
            m_wcnt = 0;
            if (m_active != 0 || !supply_ok) m_first = 1;
         end else if (e) begin
            m_wcnt = 0; m_first = 0;
         end else if (tick) begin
            if (ex) begin m_wcnt = 0; m_first = 1; end
            else m_wcnt++;
         end
         if (!supply_ok || ex) begin
            m_active = 1; m_rcnt = 0;
         end else if (m_active != 0 && tick) begin
            if (m_rcnt + 1 == rl) begin m_active = 0; m_rcnt = 0; end
            else m_rcnt++;
         end
         hq.push_front(hb_in); void'(hq.pop_back());
         fq.push_front(hb_float); void'(fq.pop_back());
      end
   end

   always @(negedge clk) begin
      if (arst_n && !done) begin
         bit exp_rn;
         exp_rn = supply_ok && (m_active == 0);
         chk("R2", int'(rst_out_n), int'(exp_rn));
         chk("R3", int'(rst_out), int'(!exp_rn));
         chk("R7", int'(wdog_fault_n), int'(m_fault == 0));
      end
   end

   // ---------------- stimulus helpers ----------------
   initial begin
      forever begin
         @(posedge clk); #1;
         cyc++;
         case (tick_mode)
            0:       tick = 1'b1;
            1:       tick = (cyc % 3 == 0);
            default: tick = 1'b0;
         endcase
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   function automatic logic probe(input int sel);
      return (sel == 0) ? rst_out_n : wdog_fault_n;
   endfunction

   task automatic count_while(input int sel, input logic lvl, input int maxc, output int n);
      n = 0;
      forever begin
         @(negedge clk);
         if (probe(sel) !== lvl) break;
         n++;
         if (n > maxc) break;
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   // ---------------- directed sequence ----------------
   initial begin
      int n;
      bit bad;
      repeat (4) step();
      arst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(rst_out_n), 0);
      chk("R3", int'(rst_out), 1);
      chk("R9", int'(wdog_fault_n), 1);

      // external mode power-up
      step(); supply_ok = 1'b1;
      count_while(0, 1'b0, 1000, n);
      chk("R2", n, E_RST);

      // narrow heartbeat pulses keep the watchdog quiet
      bad = 1'b0;
      for (int i = 0; i < 20; i++) begin
         step(); hb_in = 1'b1;
         step(); hb_in = 1'b0;
         repeat (4) step();
         if (rst_out_n !== 1'b1 || wdog_fault_n !== 1'b1) bad = 1'b1;
      end
      chk("R6", int'(bad), 0);

      // one edge, then silence: steady period
      step(); hb_in = 1'b1;
      count_while(1, 1'b1, 1000, n);
      chk("R4", n, E_SHRT + 3);
      chk("R7", int'(rst_out_n), 0);
      count_while(0, 1'b0, 1000, n);
      chk("R7", n, E_RST - 1);
      chk("R7", int'(wdog_fault_n), 0);

      // held heartbeat: long first period, repeating pulses
      count_while(0, 1'b1, 1000, n);
      chk("R5", n, E_LONG - 1);
      count_while(0, 1'b0, 1000, n);
      chk("R8", n, E_RST - 1);
      count_while(0, 1'b1, 1000, n);
      chk("R8", n, E_LONG - 1);
      count_while(0, 1'b0, 1000, n);

      // heartbeat edge clears the latched fault
      step(); hb_in = ~hb_in;
      count_while(1, 1'b0, 1000, n);
      chk("R7", n, 3);
      count_while(1, 1'b1, 1000, n);
      chk("R4", n, E_SHRT - 1);

      // supply drop with fault latched
      step(); supply_ok = 1'b0;
      @(negedge clk);
      chk("R1", int'(rst_out_n), 0);
      @(negedge clk);
      chk("R9", int'(wdog_fault_n), 1);

      // no ticks: no release
      tick_mode = 2;
      step(); step(); supply_ok = 1'b1;
      count_while(0, 1'b0, 60, n);
      chk("R11", n, 61);
      tick_mode = 0;
      count_while(0, 1'b0, 1000, n);

      // floating heartbeat disables the watchdog
      step(); hb_float = 1'b1;
      count_while(0, 1'b1, 3 * E_LONG, n);
      chk("R9", n, 3 * E_LONG + 1);
      chk("R9", int'(wdog_fault_n), 1);
      step(); hb_float = 1'b0;
      count_while(0, 1'b1, 1000, n);
      count_while(0, 1'b0, 1000, n);

      // sparse ticks, checked by the model
      tick_mode = 1;
      count_while(0, 1'b1, 2000, n);
      count_while(0, 1'b0, 2000, n);
      tick_mode = 0;

      // internal slow mode
      step(); supply_ok = 1'b0;
      step(); tb_mode = 2'b00;
      step(); supply_ok = 1'b1;
      count_while(0, 1'b0, 1000, n);
      chk("R2", n, I_RST);
      count_while(0, 1'b1, 1000, n);
      chk("R5", n, I_SLOW - 1);
      count_while(0, 1'b0, 1000, n);
      chk("R7", n, I_RST - 1);
      step(); hb_in = ~hb_in;
      count_while(1, 1'b0, 1000, n);
      chk("R7", n, 3);
      count_while(1, 1'b1, 1000, n);
      chk("R10", n, I_SLOW - 1);

      // internal fast mode
      step(); supply_ok = 1'b0;
      step(); tb_mode = 2'b01;
      step(); supply_ok = 1'b1;
      count_while(0, 1'b0, 1000, n);
      chk("R2", n, I_RST);
      step(); hb_in = ~hb_in;
      count_while(1, 1'b1, 1000, n);
      chk("R4", n, I_FAST + 3);
      count_while(0, 1'b0, 1000, n);
      chk("R7", n, I_RST - 1);
      count_while(0, 1'b1, 1000, n);
      chk("R5", n, I_SLOW - 1);

      step();
      finish_run();
   end
endmodule